// File: doc/BRIEF.md
# LCD status interrupt generator

This block holds the display status byte and produces the single display-status interrupt request. The byte has three parts. The low two bits show the current display mode. The next bit is a line-compare match flag. Four bits above that are interrupt enables that software writes. The mode and line number come in from a timing sequencer. Software writes the compare value and the enable bits through two write strobes.

Each enable gates one condition: mode 0, mode 1, mode 2, or a compare match. The enabled conditions are ORed into one internal request line. The interrupt flag is set only on a rising edge of that line, so a line that is already high never triggers again. A legacy (non-color) option also models an old hardware behaviour. In that mode, a status write can trigger the interrupt even though no enabled condition has changed.

Top module: `lcd_stat_irq`

## Requirements
- R1: After reset the status byte reads 0x80 and `irq_o` is 0.
- R2: A status write loads bits 6:3 of the written byte into the enable field. Bits 2:0 of the written byte are ignored, and bit 7 of the status byte always reads 1. The enable mapping is: bit 3 for mode 0, bit 4 for mode 1, bit 5 for mode 2 and bit 6 for compare match.
- R3: While the display is enabled, the match flag (bit 2) is updated each cycle to (compare value == `line_i`), one clock after the inputs. A compare write in the same cycle uses the newly written value.
- R4: While the display is disabled, the match flag holds its value and the mode field (bits 1:0) reads 0. A compare write still stores its value but does not change the flag, and no interrupt is raised.
- R5: `irq_o` pulses high for one cycle, one clock after the ORed line of enabled conditions goes from low to high. The mode field holds the registered `mode_i` value (0 to 3).
- R6: While the ORed line stays high, no further pulse is produced, even when sources are added or swapped. After the line falls and rises again, a new pulse is produced.
- R7: In legacy mode (`color_i` = 0), a status write while the display is enabled sets `irq_o` on the next clock. This happens when the ORed line is low and the current mode field is 0, 1 or 2.
- R8: The legacy write trigger does not occur in color mode, with the display disabled, or when the mode field is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_en_i | input | 1 | Display enable |
| color_i | input | 1 | 1 selects color mode, 0 selects legacy mode |
| mode_i | input | 2 | Current display mode from the sequencer |
| line_i | input | 8 | Current line number from the sequencer |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | 8 | Compare value write data |
| stat_wr_i | input | 1 | Status byte write strobe |
| stat_data_i | input | 8 | Status byte write data |
| stat_o | output | 8 | Readable status byte |
| irq_o | output | 1 | One-cycle interrupt-flag set pulse |

## Verification
The assertions take for granted that the mode, line and control inputs are stable across each rising edge. They also assume that `irq_o` is observed as a per-cycle set strobe and not as a level. The stimulus changes inputs only on the falling edge and holds them for whole cycles. It keeps the compare value and line in range, so the match flag is always decided by a plain equality. Enable changes are ordered so that the cycle after every status write is known, including the case where a write trigger and a line rise fall in adjacent cycles.

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en_i,
  input  logic              color_i,
  input  logic [1:0]        mode_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              cmp_wr_i,
  input  logic [LINE_W-1:0] cmp_data_i,
  input  logic              stat_wr_i,
  input  logic [7:0]        stat_data_i,
  output logic [7:0]        stat_o,
  output logic              irq_o
);

  logic [3:0]        en_q;
  logic [1:0]        mode_q;
  logic              match_q;
  logic              disp_q;
  logic              prev_q;
  logic [LINE_W-1:0] cmp_q;
  logic [LINE_W-1:0] cmp_next;
  logic              irq_line;
  logic              quirk;

  assign cmp_next = cmp_wr_i ? cmp_data_i : cmp_q;

  assign irq_line = disp_q & ((en_q[0] & (mode_q == 2'd0)) |
                              (en_q[1] & (mode_q == 2'd1)) |
                              (en_q[2] & (mode_q == 2'd2)) |
                              (en_q[3] & match_q));

  assign quirk = stat_wr_i & disp_q & ~color_i & ~irq_line & (mode_q != 2'd3);

  assign stat_o = {1'b1, en_q, match_q, mode_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      mode_q  <= '0;
      match_q <= 1'b0;
      disp_q  <= 1'b0;
      prev_q  <= 1'b0;
      cmp_q   <= '0;
      irq_o   <= 1'b0;
    end else begin
      prev_q <= irq_line;
      irq_o  <= (irq_line & ~prev_q) | quirk;
      disp_q <= disp_en_i;
      mode_q <= disp_en_i ? mode_i : 2'd0;
      cmp_q  <= cmp_next;
      if (stat_wr_i) en_q <= stat_data_i[6:3];
      if (disp_en_i) match_q <= (cmp_next == line_i);
    end
  end

  a_r4_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_q |=> !irq_o);

  a_r4_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en_i |=> $stable(stat_o[2]));

  a_r3_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en_i && cmp_wr_i) |=> (stat_o[2] == ($past(cmp_data_i) == $past(line_i))));

  a_r6_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && irq_line) |=> !irq_o);

  a_r8_color_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (color_i && !irq_line) |=> !irq_o);

endmodule

// File: tb/tb_lcd_stat_irq.sv
module tb_lcd_stat_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_en_i = 1'b0, color_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] line_i = 8'd0;
  logic       cmp_wr_i = 1'b0, stat_wr_i = 1'b0;
  logic [7:0] cmp_data_i = 8'd0, stat_data_i = 8'd0;
  logic [7:0] stat_o;
  logic       irq_o;

  lcd_stat_irq dut (
    .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en_i), .color_i(color_i),
    .mode_i(mode_i), .line_i(line_i), .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
    .stat_wr_i(stat_wr_i), .stat_data_i(stat_data_i), .stat_o(stat_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] stat;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  logic [3:0] m_en = 0;
  logic [1:0] m_mode = 0;
  logic       m_match = 0, m_disp = 0, m_prev = 0;
  logic [7:0] m_cmp = 0;

  task automatic step(input logic de, input logic col, input logic [1:0] md,
                      input logic [7:0] ln, input logic cw, input logic [7:0] cd,
                      input logic sw, input logic [7:0] sd, input string tag);
    logic line, e_irq;
    exp_t e;
    @(negedge clk);
    disp_en_i = de; color_i = col; mode_i = md; line_i = ln;
    cmp_wr_i = cw; cmp_data_i = cd; stat_wr_i = sw; stat_data_i = sd;
    @(posedge clk);
    line = m_disp && ((m_en[0] && m_mode == 0) || (m_en[1] && m_mode == 1) ||
                      (m_en[2] && m_mode == 2) || (m_en[3] && m_match));
    e_irq = (line && !m_prev) || (sw && m_disp && !col && !line && m_mode != 3);
    m_prev = line;
    if (sw) m_en = sd[6:3];
    if (cw) m_cmp = cd;
    if (de) m_match = (m_cmp == ln);
    m_mode = de ? md : 2'd0;
    m_disp = de;
    e.stat = {1'b1, m_en, m_match, m_mode};
    e.irq = e_irq;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic de, input logic col, input logic [1:0] md,
                      input logic [7:0] ln, input string tag);
    step(de, col, md, ln, 1'b0, 8'd0, 1'b0, 8'd0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (stat_o !== e.stat || irq_o !== e.irq) begin
        failures++;
        $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                 e.tag, stat_o, irq_o, e.stat, e.irq);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (stat_o !== 8'h80 || irq_o !== 1'b0) begin
      failures++;
      $display("FAIL R1: stat=%h irq=%b expected stat=80 irq=0", stat_o, irq_o);
    end
    rst_n = 1'b1;

    // R3: display on, compare 0 matches line 0
    idle(1, 1, 2'd2, 8'd0, "R3");
    idle(1, 1, 2'd2, 8'd1, "R3");
    step(1, 1, 2'd2, 8'd1, 1, 8'd1, 0, 8'd0, "R3");
    // R5: enable match, line rises in color mode
    step(1, 1, 2'd2, 8'd1, 0, 8'd0, 1, 8'h40, "R5");
    idle(1, 1, 2'd2, 8'd1, "R5");
    idle(1, 1, 2'd2, 8'd1, "R5");
    // R2: low bits of write ignored, enables cleared
    step(1, 1, 2'd2, 8'd1, 0, 8'd0, 1, 8'h07, "R2");
    idle(1, 1, 2'd2, 8'd1, "R2");
    // R2: each enable bit maps to its mode
    step(1, 1, 2'd1, 8'd2, 0, 8'd0, 1, 8'h10, "R2");
    idle(1, 1, 2'd1, 8'd2, "R2");
    idle(1, 1, 2'd0, 8'd2, "R5");
    // R6: overlap: add mode0 and mode1, move between them, line stays high
    step(1, 1, 2'd0, 8'd2, 0, 8'd0, 1, 8'h18, "R6");
    idle(1, 1, 2'd0, 8'd2, "R6");
    idle(1, 1, 2'd1, 8'd2, "R6");
    idle(1, 1, 2'd1, 8'd2, "R6");
    step(1, 1, 2'd1, 8'd2, 1, 8'd2, 1, 8'h58, "R6");
    idle(1, 1, 2'd2, 8'd2, "R6");
    idle(1, 1, 2'd2, 8'd3, "R6");
    idle(1, 1, 2'd2, 8'd3, "R6");
    idle(1, 1, 2'd0, 8'd3, "R6");
    idle(1, 1, 2'd0, 8'd3, "R6");
    idle(1, 1, 2'd3, 8'd3, "R6");
    idle(1, 1, 2'd3, 8'd3, "R6");
    // R7: legacy write quirk, modes 0,1,2 with line low
    step(1, 1, 2'd3, 8'd3, 0, 8'd0, 1, 8'h00, "R7");
    idle(1, 0, 2'd0, 8'd3, "R7");
    step(1, 0, 2'd0, 8'd3, 0, 8'd0, 1, 8'h20, "R7");
    idle(1, 0, 2'd1, 8'd3, "R7");
    step(1, 0, 2'd1, 8'd3, 0, 8'd0, 1, 8'h20, "R7");
    idle(1, 0, 2'd1, 8'd3, "R7");
    // R8: mode 3 suppresses
    idle(1, 0, 2'd3, 8'd3, "R8");
    step(1, 0, 2'd3, 8'd3, 0, 8'd0, 1, 8'h08, "R8");
    idle(1, 0, 2'd3, 8'd3, "R8");
    // R8: color mode suppresses
    idle(1, 1, 2'd1, 8'd3, "R8");
    step(1, 1, 2'd1, 8'd3, 0, 8'd0, 1, 8'h20, "R8");
    idle(1, 1, 2'd1, 8'd3, "R8");
    // R8: line already high suppresses
    step(1, 0, 2'd1, 8'd3, 0, 8'd0, 1, 8'h10, "R8");
    idle(1, 0, 2'd1, 8'd3, "R8");
    step(1, 0, 2'd1, 8'd3, 0, 8'd0, 1, 8'h30, "R8");
    idle(1, 0, 2'd1, 8'd3, "R8");
    // R4: display off, mode reads 0, match held, no irq
    idle(0, 0, 2'd0, 8'd3, "R4");
    step(0, 0, 2'd0, 8'd7, 1, 8'd7, 0, 8'd0, "R4");
    step(0, 0, 2'd1, 8'd7, 0, 8'd0, 1, 8'h48, "R4");
    idle(0, 0, 2'd2, 8'd7, "R4");
    step(0, 0, 2'd2, 8'd7, 0, 8'd0, 1, 8'h00, "R8");
    idle(0, 0, 2'd2, 8'd7, "R8");
    // R3: display back on, stored compare now matches
    step(1, 1, 2'd2, 8'd7, 0, 8'd0, 1, 8'h40, "R3");
    idle(1, 1, 2'd2, 8'd7, "R3");
    idle(1, 1, 2'd2, 8'd8, "R3");
    idle(1, 1, 2'd2, 8'd9, "R3");
    step(1, 1, 2'd2, 8'd9, 1, 8'd9, 0, 8'd0, "R3");
    idle(1, 1, 2'd2, 8'd9, "R3");
    idle(1, 1, 2'd2, 8'd9, "R3");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule